// File: doc/BRIEF.md
# AXI-Stream Packet Replay Generator

This block is a master AXI-Stream source that plays back a list of network packets held in on-chip storage. Before playback, a simple write port fills three things: a byte memory with the packets' contents, a table of per-packet byte lengths, and a packet count. Two gap values can also be set. The first is the number of idle cycles before the first packet. The second is the number of idle cycles between consecutive packets.

Packets sit back to back in the byte memory. The first packet starts at address 0, and each later packet starts where the previous one ended. During playback the block sends one beat per clock while the sink accepts. It packs bytes little-endian into the data lanes. It marks the final beat of each packet with TLAST and trims TKEEP on that beat to the lanes actually used. Once the last packet has been accepted, it raises a done flag that stays high.

A parameter selects how playback begins. It can start by itself right after reset, or it can wait for a start strobe. The byte memory and the length table are not cleared by reset. A loader can therefore fill them while reset is held, or refill them later while the block is idle.

Top module: `axis_pkt_replay`

## Requirements
- R1: Byte k of a packet appears in data lane (k mod BYTES) of beat (k div BYTES), with lane 0 in bits [7:0]. The bytes are read from consecutive memory addresses, beginning at the address right after the previous packet's last byte. The first packet begins at address 0.
- R2: While `aresetn` is low at a clock edge, `m_tvalid` and `done` are low after that edge.
- R3: With START_EN=1, the block stays idle (`m_tvalid` and `done` low) until `start` is sampled high. With START_EN=0, it triggers on the first clock edge at which reset is released.
- R4: If the block triggers at edge T, the first beat of packet 0 is presented at edge T+1+G0, where G0 is the initial gap.
- R5: After the TLAST beat of a packet is accepted, `m_tvalid` is low for exactly GI cycles, where GI is the inter-packet gap, and then the next packet begins. With GI=0 the next packet's first beat follows on the very next cycle.
- R6: Every beat except a packet's last has `m_tkeep` all ones and `m_tlast` low. On the last beat, `m_tlast` is high and `m_tkeep` = (1<<r)-1, where r (from 1 to BYTES) is the number of bytes left.
- R7: Data lanes whose `m_tkeep` bit is 0 carry zero.
- R8: A beat transfers only when `m_tvalid` and `m_tready` are both high. While a beat waits, `m_tvalid` stays high and `m_tdata`, `m_tkeep` and `m_tlast` hold. Within a packet, `m_tvalid` never drops.
- R9: `done` rises on the cycle after the last packet's TLAST beat is accepted. It then stays high, with `m_tvalid` low, until reset.
- R10: If the packet count is 0, `done` rises on the cycle after the trigger, and no beat is sent.
- R11: `cfg_kind` selects the target of a write: 0 writes a byte at address `cfg_addr`, 1 writes the length of packet `cfg_addr`, 2 writes the packet count (clamped to MAX_PKTS), and 3 writes a gap (`cfg_addr[0]`=0 selects the initial gap, 1 selects the inter-packet gap). Byte, length and count writes take effect during reset or while idle. Writes made during playback have no effect on any later output.
- R12: Reset sets the initial gap to INIT_GAP_DEF (0) and the inter-packet gap to IPG_DEF (10). A gap write made during reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous active-low reset |
| start | input | 1 | Playback start strobe (used when START_EN=1) |
| cfg_we | input | 1 | Write strobe for the load port |
| cfg_kind | input | 2 | Write target select |
| cfg_addr | input | $clog2(MEM_BYTES) | Byte address, packet index or gap select |
| cfg_wdata | input | DLY_W | Write value |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |
| m_tdata | output | DATA_W | Stream data, little-endian lanes |
| m_tkeep | output | DATA_W/8 | Byte-lane valid mask |
| m_tlast | output | 1 | Last beat of a packet |
| done | output | 1 | Sticky flag: all packets sent |

## Verification
The hardest case to reach is a pair of writes that land mid-playback: one changes a byte of a packet still to come, the other changes that packet's length. The only way to see that they were ignored is to watch that packet's later beats. The bench issues both writes a dozen cycles into a run that uses random backpressure and non-zero gaps, while packet 7 is still unsent. It then checks packet 7's data lanes, keep and last against its unchanged model in that run and in the next one. The sweep covers packet lengths from 1 to 8, so every final-beat remainder appears. It uses zero, short and long gaps, and three ready patterns: always ready, random, and alternating.

// File: rtl/pkt_replay_pkg.sv
package pkt_replay_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } rp_state_e;

  typedef enum logic [1:0] {
    WR_BYTE  = 2'd0,
    WR_LEN   = 2'd1,
    WR_COUNT = 2'd2,
    WR_GAP   = 2'd3
  } wr_kind_e;

  // A lane carries a packet byte when more than `lane` bytes remain.
  function automatic bit lane_live(input int unsigned rem, input int unsigned lane);
    return rem > lane;
  endfunction

  // The current beat closes the packet when the remainder fits in one beat.
  function automatic bit beat_is_final(input int unsigned rem, input int unsigned lanes);
    return rem <= lanes;
  endfunction

endpackage

// File: rtl/pkt_byte_store.sv
module pkt_byte_store #(
  parameter int MEM_BYTES = 256,
  parameter int BYTES     = 4,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_byte,
  input  logic [AW-1:0]      rd_ptr,
  input  logic [BYTES-1:0]   rd_keep,
  output logic [8*BYTES-1:0] rd_word
);

  logic [7:0] mem_q [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_byte;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr = rd_ptr + AW'(i);
    assign rd_word[8*i +: 8] = rd_keep[i] ? mem_q[lane_addr] : 8'h00;
  end

endmodule

// File: rtl/pkt_meta_regs.sv
module pkt_meta_regs
  import pkt_replay_pkg::*;
#(
  parameter int MAX_PKTS     = 8,
  parameter int AW           = 8,
  parameter int LEN_W        = 12,
  parameter int DLY_W        = 16,
  parameter int INIT_GAP_DEF = 0,
  parameter int IPG_DEF      = 10,
  localparam int CNT_W       = $clog2(MAX_PKTS + 1),
  localparam int PIDX_W      = $clog2(MAX_PKTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DLY_W-1:0] cfg_wdata,
  input  logic [CNT_W-1:0] look_idx,
  output logic             byte_we,
  output logic [CNT_W-1:0] pkt_count,
  output logic [DLY_W-1:0] init_gap,
  output logic [DLY_W-1:0] ipg,
  output logic [LEN_W-1:0] look_len
);

  logic [LEN_W-1:0] len_tbl_q [MAX_PKTS];
  logic [CNT_W-1:0] count_q;
  logic [DLY_W-1:0] init_gap_q, ipg_q;
  logic             load_open, gap_open;
  logic [CNT_W-1:0] count_in;

  // Storage writes are accepted in reset or idle; gap writes only when idle.
  assign load_open = !rst_n || idle;
  assign gap_open  = rst_n && idle;
  assign byte_we   = cfg_we && load_open && (cfg_kind == WR_BYTE);
  assign count_in  = (cfg_wdata > DLY_W'(MAX_PKTS)) ? CNT_W'(MAX_PKTS)
                                                    : cfg_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (cfg_we && load_open && cfg_kind == WR_LEN)
      len_tbl_q[cfg_addr[PIDX_W-1:0]] <= cfg_wdata[LEN_W-1:0];
    if (cfg_we && load_open && cfg_kind == WR_COUNT)
      count_q <= count_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_gap_q <= DLY_W'(INIT_GAP_DEF);
      ipg_q      <= DLY_W'(IPG_DEF);
    end else if (cfg_we && gap_open && cfg_kind == WR_GAP) begin
      if (cfg_addr[0]) ipg_q <= cfg_wdata;
      else             init_gap_q <= cfg_wdata;
    end
  end

  assign pkt_count = count_q;
  assign init_gap  = init_gap_q;
  assign ipg       = ipg_q;
  assign look_len  = (look_idx < CNT_W'(MAX_PKTS)) ? len_tbl_q[look_idx[PIDX_W-1:0]]
                                                   : '0;

  // R12: gap registers come out of reset at their defaults
  a_r12_gap_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (init_gap == DLY_W'(INIT_GAP_DEF)) && (ipg == DLY_W'(IPG_DEF)));

endmodule

// File: rtl/replay_fsm.sv
module replay_fsm
  import pkt_replay_pkg::*;
#(
  parameter int BYTES    = 4,
  parameter int AW       = 8,
  parameter int LEN_W    = 12,
  parameter int DLY_W    = 16,
  parameter int CNT_W    = 4,
  parameter bit START_EN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pkt_count,
  input  logic [DLY_W-1:0] init_gap,
  input  logic [DLY_W-1:0] ipg,
  input  logic [LEN_W-1:0] look_len,
  input  logic             tready,
  output logic [CNT_W-1:0] look_idx,
  output logic [AW-1:0]    rd_ptr,
  output logic             tvalid,
  output logic [BYTES-1:0] tkeep,
  output logic             tlast,
  output logic             done,
  output logic             idle
);

  rp_state_e        st_q;
  logic [CNT_W-1:0] idx_q;
  logic [AW-1:0]    ptr_q;
  logic [LEN_W-1:0] rem_q;
  logic [DLY_W-1:0] gcnt_q;

  // Named internal events
  logic trig, beat_fire, last_fire, final_pkt, gap_over;

  assign trig      = (st_q == ST_IDLE) && (!START_EN || start);
  assign tvalid    = (st_q == ST_SEND);
  assign tlast     = beat_is_final(32'(rem_q), BYTES);
  assign beat_fire = tvalid && tready;
  assign last_fire = beat_fire && tlast;
  assign final_pkt = (idx_q + CNT_W'(1)) == pkt_count;
  assign gap_over  = (st_q == ST_GAP) && (gcnt_q == '0);
  assign look_idx  = (st_q == ST_SEND) ? idx_q + CNT_W'(1) : idx_q;
  assign rd_ptr    = ptr_q;
  assign done      = (st_q == ST_DONE);
  assign idle      = (st_q == ST_IDLE);

  for (genvar i = 0; i < BYTES; i++) begin : g_keep
    assign tkeep[i] = lane_live(32'(rem_q), i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
      gcnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (trig) begin
          idx_q <= '0;
          ptr_q <= '0;
          if (pkt_count == '0) begin
            st_q <= ST_DONE;
          end else if (init_gap == '0) begin
            st_q  <= ST_SEND;
            rem_q <= look_len;
          end else begin
            st_q   <= ST_GAP;
            gcnt_q <= init_gap - DLY_W'(1);
          end
        end
        ST_GAP: if (gap_over) begin
          st_q  <= ST_SEND;
          rem_q <= look_len;
        end else begin
          gcnt_q <= gcnt_q - DLY_W'(1);
        end
        ST_SEND: if (beat_fire) begin
          if (!tlast) begin
            ptr_q <= ptr_q + AW'(BYTES);
            rem_q <= rem_q - LEN_W'(BYTES);
          end else begin
            ptr_q <= ptr_q + AW'(rem_q);
            idx_q <= idx_q + CNT_W'(1);
            if (final_pkt) begin
              st_q <= ST_DONE;
            end else if (ipg == '0) begin
              rem_q <= look_len;
            end else begin
              st_q   <= ST_GAP;
              gcnt_q <= ipg - DLY_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  logic [BYTES-1:0] keep_inc;
  assign keep_inc = tkeep + BYTES'(1);

  // R6: non-final beats carry every lane
  a_r6_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid && !tlast |-> &tkeep);
  // R6: keep is a non-empty run of ones starting at lane 0
  a_r6_keep_contig: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid |-> (tkeep != '0) && ((keep_inc & tkeep) == '0));
  // R5: zero inter-packet gap gives back-to-back packets
  a_r5_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire && !final_pkt && (ipg == '0) |=> tvalid);
  // R9: done is sticky and quiet
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tvalid);
  // R10: empty list completes immediately
  a_r10_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    trig && (pkt_count == '0) |=> done);

endmodule

// File: rtl/axis_pkt_replay.sv
module axis_pkt_replay
  import pkt_replay_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int MEM_BYTES    = 256,
  parameter int MAX_PKTS     = 8,
  parameter int LEN_W        = 12,
  parameter int DLY_W        = 16,
  parameter int INIT_GAP_DEF = 0,
  parameter int IPG_DEF      = 10,
  parameter bit START_EN     = 1'b0,
  localparam int BYTES       = DATA_W / 8,
  localparam int AW          = $clog2(MEM_BYTES),
  localparam int CNT_W       = $clog2(MAX_PKTS + 1)
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic              start,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DLY_W-1:0]  cfg_wdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [BYTES-1:0]  m_tkeep,
  output logic              m_tlast,
  output logic              done
);

  logic             byte_we, idle;
  logic [CNT_W-1:0] pkt_count, look_idx;
  logic [DLY_W-1:0] init_gap, ipg;
  logic [LEN_W-1:0] look_len;
  logic [AW-1:0]    rd_ptr;

  pkt_meta_regs #(
    .MAX_PKTS(MAX_PKTS), .AW(AW), .LEN_W(LEN_W), .DLY_W(DLY_W),
    .INIT_GAP_DEF(INIT_GAP_DEF), .IPG_DEF(IPG_DEF)
  ) u_meta (
    .clk(aclk), .rst_n(aresetn), .idle(idle),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .look_idx(look_idx), .byte_we(byte_we), .pkt_count(pkt_count),
    .init_gap(init_gap), .ipg(ipg), .look_len(look_len)
  );

  replay_fsm #(
    .BYTES(BYTES), .AW(AW), .LEN_W(LEN_W), .DLY_W(DLY_W), .CNT_W(CNT_W),
    .START_EN(START_EN)
  ) u_fsm (
    .clk(aclk), .rst_n(aresetn), .start(start), .pkt_count(pkt_count),
    .init_gap(init_gap), .ipg(ipg), .look_len(look_len), .tready(m_tready),
    .look_idx(look_idx), .rd_ptr(rd_ptr), .tvalid(m_tvalid), .tkeep(m_tkeep),
    .tlast(m_tlast), .done(done), .idle(idle)
  );

  pkt_byte_store #(
    .MEM_BYTES(MEM_BYTES), .BYTES(BYTES)
  ) u_store (
    .clk(aclk), .wr_en(byte_we), .wr_addr(cfg_addr), .wr_byte(cfg_wdata[7:0]),
    .rd_ptr(rd_ptr), .rd_keep(m_tkeep), .rd_word(m_tdata)
  );

  logic [DATA_W-1:0] keep_bits;
  for (genvar i = 0; i < BYTES; i++) begin : g_kexp
    assign keep_bits[8*i +: 8] = {8{m_tkeep[i]}};
  end

  // R8: a waiting beat holds its contents
  a_r8_stall_hold: assert property (@(posedge aclk) disable iff (!aresetn)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                              && $stable(m_tlast));
  // R7: lanes outside keep are zero
  a_r7_lane_zero: assert property (@(posedge aclk) disable iff (!aresetn)
    m_tvalid |-> (m_tdata & ~keep_bits) == '0);

endmodule

// File: tb/axis_pkt_replay_bench.sv
module axis_pkt_replay_bench;
  localparam int DW = 32, NB = 4, NP = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_main_n = 1'b0, rst_auto_n = 1'b0, start = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_kind = '0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic tready = 1'b1;
  logic m_tvalid, m_tlast, m_done, a_tvalid, a_tlast, a_done;
  logic [DW-1:0] m_tdata, a_tdata;
  logic [NB-1:0] m_tkeep, a_tkeep;

  axis_pkt_replay #(.START_EN(1'b1)) u_axis_pkt_replay (
    .aclk(clk), .aresetn(rst_main_n), .start(start), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .m_tvalid(m_tvalid), .m_tready(tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .done(m_done));

  axis_pkt_replay #(.START_EN(1'b0)) u_axis_pkt_replay_auto (
    .aclk(clk), .aresetn(rst_auto_n), .start(1'b0), .cfg_we(cfg_we),
    .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .m_tvalid(a_tvalid), .m_tready(tready), .m_tdata(a_tdata), .m_tkeep(a_tkeep),
    .m_tlast(a_tlast), .done(a_done));

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model
  logic [7:0] mdl [256];
  int lens [NP] = '{5, 1, 4, 8, 3, 7, 2, 6};
  int count = NP, gap0 = 0, gapn = 0;
  bit tamper_on = 0;
  localparam int TAMPER_ADDR = 32;

  // Ready pattern driver
  int rmode = 0;
  logic [15:0] lf = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    case (rmode)
      0: tready = 1'b1;
      1: tready = lf[0] | lf[5];
      default: tready = ~tready;
    endcase
  end

  // Monitor for the start-gated instance
  int mon_st = 0, pkt = 0, off = 0, base = 0, lowcnt = 0;
  bit in_pkt = 0, prev_stall = 0;
  logic [DW-1:0] s_data;
  logic [NB-1:0] s_keep;
  logic s_last;
  always @(negedge clk) begin
    if (!rst_main_n) begin
      mon_st = 0; prev_stall = 0; in_pkt = 0;
    end else begin
      if (prev_stall)
        check(m_tvalid && m_tdata == s_data && m_tkeep == s_keep && m_tlast == s_last,
              "R8", "stalled beat held", {m_tvalid, m_tdata}, {1'b1, s_data});
      case (mon_st)
        0: begin
          check(!m_tvalid && !m_done, "R3", "idle before start", {m_tvalid, m_done}, 0);
          if (start) begin
            pkt = 0; off = 0; base = 0; lowcnt = 0; in_pkt = 0;
            mon_st = (count == 0) ? 2 : 1;
          end
        end
        1: begin
          check(!m_done, "R9", "done early", m_done, 0);
          if (!m_tvalid) begin
            check(!in_pkt, "R8", "valid dropped mid-packet", 0, 1);
            lowcnt++;
          end else begin
            logic [DW-1:0] ew, em;
            logic [NB-1:0] ek;
            bit el, hit;
            int rem;
            if (!in_pkt) begin
              check(lowcnt == (pkt == 0 ? gap0 : gapn), (pkt == 0) ? "R4" : "R5",
                    "idle cycles before packet", lowcnt, (pkt == 0 ? gap0 : gapn));
              in_pkt = 1;
            end
            ew = '0; em = '0; ek = '0; hit = 0;
            rem = lens[pkt] - off;
            for (int i = 0; i < NB; i++) begin
              if (i < rem) begin
                ew[8*i +: 8] = mdl[(base + off + i) % 256];
                em[8*i +: 8] = 8'hFF;
                ek[i] = 1'b1;
                if (base + off + i == TAMPER_ADDR) hit = tamper_on;
              end
            end
            el = (rem <= NB);
            check(((m_tdata ^ ew) & em) == '0, hit ? "R11" : "R1", "data lanes", m_tdata, ew);
            check((m_tdata & ~em) == '0, "R7", "unused lanes zero", m_tdata, ew);
            check(m_tkeep == ek, hit ? "R11" : "R6", "tkeep", m_tkeep, ek);
            check(m_tlast == el, "R6", "tlast", m_tlast, el);
            if (tready) begin
              if (el) begin
                base += lens[pkt]; pkt++; off = 0; in_pkt = 0; lowcnt = 0;
                if (pkt == count) mon_st = 2;
              end else off += NB;
            end
          end
        end
        2: begin
          check(m_done && !m_tvalid, (count == 0) ? "R10" : "R9", "done rises",
                {m_done, m_tvalid}, 2);
          mon_st = 3;
        end
        default: check(m_done && !m_tvalid, "R9", "done sticky", {m_done, m_tvalid}, 2);
      endcase
      prev_stall = m_tvalid && !tready;
      s_data = m_tdata; s_keep = m_tkeep; s_last = m_tlast;
    end
  end

  // Monitor for the self-starting instance (default gaps)
  int a_st = 0, a_pkt = 0, a_low = 0;
  bit a_in = 0;
  always @(negedge clk) begin
    if (!rst_auto_n) begin
      a_st = 0; a_in = 0;
    end else begin
      case (a_st)
        0: begin a_low = 0; a_pkt = 0; a_st = 1; end
        1: begin
          if (!a_tvalid) begin
            check(!a_in, "R8", "auto valid dropped", 0, 1);
            a_low++;
          end else begin
            if (!a_in) begin
              check(a_low == (a_pkt == 0 ? 0 : 10), (a_pkt == 0) ? "R3" : "R12",
                    "auto default gap", a_low, (a_pkt == 0 ? 0 : 10));
              a_in = 1;
            end
            if (tready && a_tlast) begin
              a_pkt++; a_in = 0; a_low = 0;
              if (a_pkt == NP) a_st = 2;
            end
          end
        end
        2: begin check(a_done && !a_tvalid, "R9", "auto done", a_done, 1); a_st = 3; end
        default: ;
      endcase
    end
  end

  task automatic wr(input int k, input int a, input int d);
    cfg_we = 1'b1; cfg_kind = 2'(k); cfg_addr = 8'(a); cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1; @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_main_done();
    int k = 0;
    while (mon_st != 3 && k < 5000) begin @(posedge clk); #1; k++; end
    check(mon_st == 3, "R9", "run completed", mon_st, 3);
  endtask

  task automatic reset_main();
    rst_main_n = 1'b0;
    repeat (2) begin @(posedge clk); #1; end
    check(!m_tvalid && !m_done, "R2", "reset state", {m_tvalid, m_done}, 0);
    rst_main_n = 1'b1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    @(posedge clk); #1;
    for (int a = 0; a < 256; a++) begin
      mdl[a] = 8'((a * 29 + 7) & 255);
      wr(0, a, int'(mdl[a]));
    end
    for (int p = 0; p < NP; p++) wr(1, p, lens[p]);
    wr(2, 0, NP);
    wr(3, 1, 3);                       // R12: ignored while in reset
    check(!m_tvalid && !m_done && !a_tvalid && !a_done, "R2", "held in reset",
          {m_tvalid, m_done, a_tvalid, a_done}, 0);
    rst_main_n = 1'b1; rst_auto_n = 1'b1;
    repeat (20) begin @(posedge clk); #1; end

    // Run 1: no gaps, always ready
    wr(3, 0, 0); wr(3, 1, 0); gap0 = 0; gapn = 0; rmode = 0;
    pulse_start();
    wait_main_done();
    repeat (120) begin @(posedge clk); #1; end
    check(a_st == 3, "R3", "self-started instance finished", a_st, 3);

    // Run 2: short gaps, random ready, writes during playback
    reset_main();
    wr(3, 0, 3); wr(3, 1, 2); gap0 = 3; gapn = 2; rmode = 1;
    pulse_start();
    repeat (12) begin @(posedge clk); #1; end
    check(mon_st == 1 && pkt < 7, "R11", "still busy before late writes", pkt, 0);
    wr(0, TAMPER_ADDR, int'(~mdl[TAMPER_ADDR]));
    wr(1, 7, 1);
    tamper_on = 1;
    wait_main_done();

    // Run 3: longer gaps, alternating ready
    reset_main();
    wr(3, 0, 1); wr(3, 1, 5); gap0 = 1; gapn = 5; rmode = 2;
    pulse_start();
    wait_main_done();

    // Run 4: empty packet list
    reset_main();
    wr(2, 0, 0); count = 0; rmode = 0;
    pulse_start();
    repeat (4) begin @(posedge clk); #1; end
    check(mon_st == 3 && m_done, "R10", "empty list done", m_done, 1);

    finish_up();
  end

endmodule